// File: doc/BRIEF.md
# Interrupt Pending and Gating Controller

This block gathers level-sensitive hardware interrupt events and two software interrupt bits into one 13-bit status word. It combines that word with a per-bit enable mask and tells the core, one cycle later, whether an interrupt may be taken now. Hardware events arrive one at a time as an index plus a level. An in-range index copies its level into its status bit, and an index outside the supported range is dropped. A small register write port loads the enable mask, a vector-spacing field and the software interrupt bits.

Taking an interrupt is gated by a global enable input and a debug-mode input. When the request is taken, a registered vector index names the highest-numbered bit of the masked pending set. A raw request output shows that any status bit is set, masked or not. A wake output tells a halted core that an enabled interrupt is pending, whatever the global enable says. The request is held by a two-state machine. GATE_IDLE moves to GATE_TAKE when the gate is open and the masked set is nonzero. GATE_TAKE returns to GATE_IDLE when either condition drops. Each state loops on itself otherwise.

Top module: `irqg_top`

## Requirements
- R1: An event whose index is 11 or higher (the index input is 4 bits, range 0 to 15) is ignored, and the status word is unchanged after it.
- R2: An event with index k in 0 to 10 writes its level into status bit k+2 at the next clock edge: 1 sets the bit and 0 clears it.
- R3: raw_req_o is 1 whenever any status bit is set, including bits whose enable is 0.
- R4: take_o is 1 in a cycle only if, at the previous edge, glob_ie_i was 1 and dbg_mode_i was 0.
- R5: The pending set is status AND enable mask. take_o becomes 1 one edge after the pending set is nonzero with the gate open, and becomes 0 one edge after the pending set is empty.
- R6: While take_o is 1, vec_idx_o holds the position of the most significant set bit of the pending set sampled at the previous edge.
- R7: wake_o is 1 exactly when raw_req_o is 1 and the pending set is nonzero, independent of glob_ie_i and dbg_mode_i.
- R8: A write with cfg_sel_i = 0 loads the enable mask from cfg_wdata_i[12:0] and the vector spacing from cfg_wdata_i[15:13], which appears on vec_spacing_o.
- R9: A write with cfg_sel_i = 1 loads status bits 1:0 from cfg_wdata_i[1:0] and leaves the mask and the spacing unchanged.
- R10: Reset clears the enable mask, the vector spacing, the whole status word and take_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_evt_valid | input | 1 | Interrupt line event strobe |
| line_evt_idx | input | 4 | Hardware line index of the event |
| line_evt_level | input | 1 | New level of the line |
| glob_ie_i | input | 1 | Global interrupt enable |
| dbg_mode_i | input | 1 | Core is in debug mode |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0: mask and spacing, 1: software bits |
| cfg_wdata_i | input | 16 | Register write data |
| take_o | output | 1 | Take-interrupt request |
| vec_idx_o | output | 4 | Winning status bit index, valid with take_o |
| status_o | output | 13 | Raw status word |
| raw_req_o | output | 1 | Any status bit set |
| wake_o | output | 1 | Enabled interrupt pending, for a halted core |
| vec_spacing_o | output | 3 | Stored vector-spacing field |

## Verification
The hardest case to reach is wake_o held high while take_o stays low. This needs a pending, enabled bit together with a closed gate. The stimulus first opens the gate and confirms a take, then raises the debug flag and later drops the global enable, without touching the status word. A second hard case is proving that an out-of-range event changed nothing. Three such events are sent with level 1 and level 0 while higher bits are pending, and the status word and the winning index must come back exactly as before.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
    parameter int STAT_W  = 13;
    parameter int SW_BITS = 2;
    parameter int NUM_HW  = STAT_W - SW_BITS;
    parameter int IDX_W   = $clog2(STAT_W);
    parameter int EVT_W   = 4;
    parameter int SPC_W   = 3;
    parameter int CFG_W   = STAT_W + SPC_W;

    typedef enum logic [0:0] {
        CFG_SEL_EN = 1'b0,
        CFG_SEL_SW = 1'b1
    } cfg_sel_t;

    typedef enum logic [0:0] {
        GATE_IDLE = 1'b0,
        GATE_TAKE = 1'b1
    } gate_state_t;
endpackage

// File: rtl/irqg_status_reg.sv
module irqg_status_reg #(
    parameter int STAT_W  = irqg_pkg::STAT_W,
    parameter int SW_BITS = irqg_pkg::SW_BITS,
    parameter int EVT_W   = irqg_pkg::EVT_W,
    localparam int NUM_HW = STAT_W - SW_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid_i,
    input  logic [EVT_W-1:0]   evt_idx_i,
    input  logic               evt_level_i,
    input  logic               sw_we_i,
    input  logic [SW_BITS-1:0] sw_data_i,
    output logic [STAT_W-1:0]  status_o
);
    logic [NUM_HW-1:0] hit;

    generate
        for (genvar k = 0; k < NUM_HW; k++) begin : g_hit
            assign hit[k] = evt_valid_i && (evt_idx_i == EVT_W'(k));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= '0;
        end else begin
            if (sw_we_i) begin
                status_o[SW_BITS-1:0] <= sw_data_i;
            end
            for (int k = 0; k < NUM_HW; k++) begin
                if (hit[k]) begin
                    status_o[k+SW_BITS] <= evt_level_i;
                end
            end
        end
    end

    // R1
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && (evt_idx_i >= EVT_W'(NUM_HW)) && !sw_we_i) |=> $stable(status_o));

    // R2
    line_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && (evt_idx_i < EVT_W'(NUM_HW)))
        |=> (status_o[$past(evt_idx_i) + SW_BITS] == $past(evt_level_i)));
endmodule

// File: rtl/irqg_cfg_reg.sv
module irqg_cfg_reg #(
    parameter int STAT_W = irqg_pkg::STAT_W,
    parameter int SPC_W  = irqg_pkg::SPC_W,
    localparam int CFG_W = STAT_W + SPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we_i,
    input  logic [CFG_W-1:0]  wdata_i,
    output logic [STAT_W-1:0] mask_o,
    output logic [SPC_W-1:0]  spacing_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o    <= '0;
            spacing_o <= '0;
        end else if (en_we_i) begin
            mask_o    <= wdata_i[STAT_W-1:0];
            spacing_o <= wdata_i[CFG_W-1:STAT_W];
        end
    end

    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we_i |=> ($stable(mask_o) && $stable(spacing_o)));
endmodule

// File: rtl/irqg_prio_enc.sv
module irqg_prio_enc #(
    parameter int STAT_W = irqg_pkg::STAT_W,
    localparam int IDX_W = $clog2(STAT_W)
) (
    input  logic [STAT_W-1:0] vec_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < STAT_W; i++) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign any_o = |vec_i;
endmodule

// File: rtl/irqg_gate_fsm.sv
module irqg_gate_fsm
    import irqg_pkg::*;
#(
    parameter int STAT_W = irqg_pkg::STAT_W,
    localparam int IDX_W = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_open_i,
    input  logic              any_pend_i,
    input  logic [IDX_W-1:0]  win_idx_i,
    input  logic [STAT_W-1:0] masked_i,
    output logic              take_o,
    output logic [IDX_W-1:0]  vec_o
);
    gate_state_t state_q, state_d;
    logic        eligible;

    assign eligible = gate_open_i && any_pend_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: if (eligible)  state_d = GATE_TAKE;
            GATE_TAKE: if (!eligible) state_d = GATE_IDLE;
            default:                  state_d = GATE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_o <= '0;
        end else if (eligible) begin
            vec_o <= win_idx_i;
        end else begin
            vec_o <= '0;
        end
    end

    assign take_o = (state_q == GATE_TAKE);

    // R4
    gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(gate_open_i));

    // R6
    vec_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (($past(masked_i) >> vec_o) == STAT_W'(1)));
endmodule

// File: rtl/irqg_top.sv
module irqg_top
    import irqg_pkg::*;
#(
    parameter int STAT_W  = irqg_pkg::STAT_W,
    parameter int SW_BITS = irqg_pkg::SW_BITS,
    parameter int EVT_W   = irqg_pkg::EVT_W,
    parameter int SPC_W   = irqg_pkg::SPC_W,
    localparam int IDX_W  = $clog2(STAT_W),
    localparam int CFG_W  = STAT_W + SPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_evt_valid,
    input  logic [EVT_W-1:0]  line_evt_idx,
    input  logic              line_evt_level,
    input  logic              glob_ie_i,
    input  logic              dbg_mode_i,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic              take_o,
    output logic [IDX_W-1:0]  vec_idx_o,
    output logic [STAT_W-1:0] status_o,
    output logic              raw_req_o,
    output logic              wake_o,
    output logic [SPC_W-1:0]  vec_spacing_o
);
    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] masked;
    logic [IDX_W-1:0]  win_idx;
    logic              any_pend;
    logic              en_we;
    logic              sw_we;

    assign en_we = cfg_we_i && (cfg_sel_i == CFG_SEL_EN);
    assign sw_we = cfg_we_i && (cfg_sel_i == CFG_SEL_SW);

    irqg_status_reg #(.STAT_W(STAT_W), .SW_BITS(SW_BITS), .EVT_W(EVT_W)) status_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_valid_i (line_evt_valid),
        .evt_idx_i   (line_evt_idx),
        .evt_level_i (line_evt_level),
        .sw_we_i     (sw_we),
        .sw_data_i   (cfg_wdata_i[SW_BITS-1:0]),
        .status_o    (status_o)
    );

    irqg_cfg_reg #(.STAT_W(STAT_W), .SPC_W(SPC_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we_i   (en_we),
        .wdata_i   (cfg_wdata_i),
        .mask_o    (mask),
        .spacing_o (vec_spacing_o)
    );

    assign masked = status_o & mask;

    irqg_prio_enc #(.STAT_W(STAT_W)) enc_i (
        .vec_i (masked),
        .any_o (any_pend),
        .idx_o (win_idx)
    );

    irqg_gate_fsm #(.STAT_W(STAT_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_open_i (glob_ie_i && !dbg_mode_i),
        .any_pend_i  (any_pend),
        .win_idx_i   (win_idx),
        .masked_i    (masked),
        .take_o      (take_o),
        .vec_o       (vec_idx_o)
    );

    assign raw_req_o = |status_o;
    assign wake_o    = raw_req_o && any_pend;

    // R4
    dbg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode_i |=> !take_o);

    // R5
    empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_o |=> !take_o);
endmodule

// File: tb/irqg_top_tb_top.sv
`timescale 1ns/1ps
module irqg_top_tb_top;
    localparam int STW = 13;

    typedef struct {
        string      tag;
        logic       take;
        logic [3:0] vec;
        logic       raw;
        logic       wake;
        logic [12:0] st;
        logic [2:0] sp;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_v = 1'b0;
    logic [3:0] evt_idx = '0;
    logic evt_lvl = 1'b0;
    logic ie = 1'b0;
    logic dbg = 1'b0;
    logic cfg_we = 1'b0;
    logic cfg_sel = 1'b0;
    logic [15:0] cfg_wd = '0;
    logic take;
    logic [3:0] vec;
    logic [12:0] status;
    logic raw, wake;
    logic [2:0] spc;

    int tests = 0;
    int fails = 0;
    exp_t q[$];

    logic [12:0] m_st = '0;
    logic [12:0] m_mk = '0;
    logic [2:0]  m_sp = '0;

    always #4 clk = ~clk;

    irqg_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .line_evt_valid(evt_v), .line_evt_idx(evt_idx), .line_evt_level(evt_lvl),
        .glob_ie_i(ie), .dbg_mode_i(dbg),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wd),
        .take_o(take), .vec_idx_o(vec), .status_o(status),
        .raw_req_o(raw), .wake_o(wake), .vec_spacing_o(spc)
    );

    function automatic logic [3:0] top_bit(input logic [12:0] v);
        for (int i = STW - 1; i >= 0; i--) begin
            if (v[i]) return 4'(i);
        end
        return 4'd0;
    endfunction

    task automatic push(input string tag);
        exp_t e;
        logic [12:0] pm;
        pm = m_st & m_mk;
        e.tag  = tag;
        e.take = ie && !dbg && (pm != 0);
        e.vec  = top_bit(pm);
        e.raw  = (m_st != 0);
        e.wake = (m_st != 0) && (pm != 0);
        e.st   = m_st;
        e.sp   = m_sp;
        q.push_back(e);
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(take == e.take, e.tag, "take", int'(take), int'(e.take));
                chk(raw == e.raw, e.tag, "raw_req", int'(raw), int'(e.raw));
                chk(wake == e.wake, e.tag, "wake", int'(wake), int'(e.wake));
                chk(status == e.st, e.tag, "status", int'(status), int'(e.st));
                chk(spc == e.sp, e.tag, "spacing", int'(spc), int'(e.sp));
                if (e.take) begin
                    chk(vec == e.vec, e.tag, "vec_idx", int'(vec), int'(e.vec));
                end
            end
        end
    end

    task automatic settle(input string tag);
        @(posedge clk); #1;
        push(tag);
    endtask

    task automatic line_evt(input logic [3:0] idx, input logic lvl, input string tag);
        @(posedge clk); #1;
        evt_v = 1'b1; evt_idx = idx; evt_lvl = lvl;
        @(posedge clk); #1;
        evt_v = 1'b0;
        if (idx < 4'd11) m_st[idx + 2] = lvl;
        settle(tag);
    endtask

    task automatic cfg_write(input logic sel, input logic [15:0] d, input string tag);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wd = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (!sel) begin
            m_mk = d[12:0];
            m_sp = d[15:13];
        end else begin
            m_st[1:0] = d[1:0];
        end
        settle(tag);
    endtask

    task automatic set_gate(input logic i, input logic d, input string tag);
        @(posedge clk); #1;
        ie = i; dbg = d;
        @(posedge clk); #1;
        settle(tag);
    endtask

    task automatic do_reset(input string tag);
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        m_st = '0; m_mk = '0; m_sp = '0;
        settle(tag);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle("R10 reset state");
        line_evt(4'd3, 1'b1, "R2 R3 masked raw");
        cfg_write(1'b0, {3'd5, 13'h1FFF}, "R8 R7 mask load, ie off");
        set_gate(1'b1, 1'b0, "R4 R5 R6 take line3");
        line_evt(4'd9, 1'b1, "R6 higher wins");
        line_evt(4'd10, 1'b1, "R6 top bit 12");
        line_evt(4'd11, 1'b1, "R1 index 11 ignored");
        line_evt(4'd15, 1'b1, "R1 index 15 ignored");
        line_evt(4'd13, 1'b0, "R1 index 13 ignored");
        set_gate(1'b1, 1'b1, "R4 R7 debug blocks");
        set_gate(1'b0, 1'b0, "R4 R7 ie off wake");
        set_gate(1'b1, 1'b0, "R4 reopen");
        cfg_write(1'b0, {3'd2, 13'h0FFF}, "R5 R8 partial mask");
        line_evt(4'd10, 1'b0, "R2 clear bit12");
        line_evt(4'd9, 1'b0, "R2 clear bit11");
        line_evt(4'd3, 1'b0, "R5 empty set");
        cfg_write(1'b1, 16'h0001, "R9 sw bit0");
        cfg_write(1'b1, 16'hE003, "R9 sw bits, mask kept");
        line_evt(4'd0, 1'b1, "R2 R6 line0 bit2");
        cfg_write(1'b0, 16'h0000, "R5 R3 mask off");
        cfg_write(1'b0, {3'd7, 13'h1FFF}, "R8 spacing 7");
        do_reset("R10 mid-run reset");
        line_evt(4'd4, 1'b1, "R10 mask cleared");
        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule